// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single read or write column command into the stream of column addresses that an SDRAM burst visits, one address per clock. On a start pulse it captures the starting column, a 3-bit burst length code and a burst order bit. Starting on the next clock it presents one column per cycle until the programmed number of beats is done. It flags the final beat, so a memory controller can walk the data path in step with the device's internal column counter.

The block is a three-state machine:

- **IDLE**: no burst is active.
- **BURST**: a fixed-length burst of 1, 2, 4 or 8 beats.
- **PAGE**: a sequential full-page burst that has no natural end.

The transitions are:

- **LOAD** (any state to BURST or PAGE, on start). A new start is accepted on any cycle, including mid-burst, and restarts the sequence at its own column. Nothing forces alignment to an even beat.
- **STOP** (BURST or PAGE to IDLE, on a burst-stop pulse). The burst ends at once.
- **FINISH** (BURST to IDLE, after the last beat).
- **ADVANCE** (BURST or PAGE to itself, stepping the beat index).

Two orders are supported:

- **Sequential**: adds the beat index to the low bits of the start column, modulo the burst length.
- **Interleaved**: XORs the beat index into those low bits.

In both orders the column bits above the burst window stay fixed. Length codes that are reserved, and full page combined with interleaved order, are run as single-beat bursts. They also set a sticky error flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid and col_last are low and cfg_err is low.
- R2: When cmd_start is high at a clock edge, col_valid is high after that edge and col_addr equals the captured cmd_col.
- R3: len_code 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. col_last is high on exactly the final beat. col_valid is low on the following cycle unless a new start arrives.
- R4: With burst_ilv = 0, beat k has low log2(BL) bits equal to (start + k) mod BL. The upper column bits equal those of the start column.
- R5: With burst_ilv = 1, beat k has col_addr equal to the start column XOR k.
- R6: len_code 3'b111 with burst_ilv = 0 is full page. Each beat is the previous column plus one, modulo 512 over the whole 9-bit column. col_last is never raised, and the burst continues until cmd_stop or cmd_start.
- R7: len_code 3'b100, 3'b101 and 3'b110, and 3'b111 with burst_ilv = 1, run a single beat at the start column. They set cfg_err, which stays high until reset.
- R8: cmd_stop without cmd_start ends an active burst, so col_valid is low after that edge. cmd_stop while idle has no effect. cmd_start in the same cycle as cmd_stop takes priority.
- R9: cmd_start during an active burst restarts the sequence at the new column and length on the next cycle, on any beat.
- R10: While a burst is active, one new column is presented each clock with no gap until col_last, cmd_stop or a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start of a read or write burst |
| cmd_col | input | 9 | Starting column, captured with cmd_start |
| len_code | input | 3 | Burst length code, captured with cmd_start |
| burst_ilv | input | 1 | Order bit: 0 sequential, 1 interleaved |
| cmd_stop | input | 1 | Burst-stop command |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | 9 | Column address of the current beat |
| col_last | output | 1 | Current beat is the last of a fixed-length burst |
| cfg_err | output | 1 | Sticky flag for a reserved length or type combination |

## Verification
The assertions assume that cmd_start and cmd_stop carry known values at every clock edge once reset is released. They also assume that cmd_col, len_code and burst_ilv are only meaningful in the cycle of a start. The bench drives every input on the falling edge and clears cmd_start after one cycle. It holds reset across the first edges, so each property begins from a defined state. The stimulus combines stop and start in the same cycle, and restarts on beats other than the first, so that the priority rules are actually reached.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam int unsigned LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] CODE_FULL_PAGE = 3'b111;
    localparam int unsigned FIXED_CODES = 4;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] code,
    input  logic                  ilv,
    output logic [COL_W-1:0]      last_idx,
    output logic [COL_W-1:0]      win_mask,
    output logic                  full_page,
    output logic                  reserved
);
    always_comb begin
        last_idx  = '0;
        win_mask  = '0;
        full_page = 1'b0;
        reserved  = 1'b0;
        if (code < LEN_CODE_W'(FIXED_CODES)) begin
            // fixed length 2**code beats
            win_mask = COL_W'((1 << code) - 1);
            last_idx = win_mask;
        end else if (code == CODE_FULL_PAGE && !ilv) begin
            full_page = 1'b1;
            win_mask  = '1;
            last_idx  = '1;
        end else begin
            reserved = 1'b1;
        end
    end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] win_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] ilv_addr;
    logic [COL_W-1:0] sum;

    always_comb begin
        sum      = base + beat;
        seq_addr = (base & ~win_mask) | (sum & win_mask);
        ilv_addr = base ^ (beat & win_mask);
        addr     = ilv ? ilv_addr : seq_addr;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_start,
    input  logic [COL_W-1:0]      cmd_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  burst_ilv,
    input  logic                  cmd_stop,
    output logic                  col_valid,
    output logic [COL_W-1:0]      col_addr,
    output logic                  col_last,
    output logic                  cfg_err
);
    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic [COL_W-1:0] endi_q, endi_d;
    logic             ilv_q, ilv_d;
    logic             err_q, err_d;

    logic [COL_W-1:0] dec_last;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_rsvd;
    logic             at_end;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code      (len_code),
        .ilv       (burst_ilv),
        .last_idx  (dec_last),
        .win_mask  (dec_mask),
        .full_page (dec_full),
        .reserved  (dec_rsvd)
    );

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base     (base_q),
        .beat     (beat_q),
        .win_mask (mask_q),
        .ilv      (ilv_q),
        .addr     (col_addr)
    );

    assign at_end = (beat_q == endi_q);

    // next-state process
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        mask_d  = mask_q;
        endi_d  = endi_q;
        ilv_d   = ilv_q;
        err_d   = err_q;
        if (cmd_start) begin
            // LOAD
            state_d = dec_full ? ST_PAGE : ST_BURST;
            base_d  = cmd_col;
            beat_d  = '0;
            mask_d  = dec_mask;
            endi_d  = dec_last;
            ilv_d   = burst_ilv & ~dec_rsvd;
            err_d   = err_q | dec_rsvd;
        end else if (cmd_stop) begin
            // STOP
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: begin
                    if (at_end) state_d = ST_IDLE;      // FINISH
                    else        beat_d  = beat_q + 1'b1; // ADVANCE
                end
                ST_PAGE:  beat_d = beat_q + 1'b1;        // ADVANCE, wraps
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            endi_q  <= '0;
            ilv_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            mask_q  <= mask_d;
            endi_q  <= endi_d;
            ilv_q   <= ilv_d;
            err_q   <= err_d;
        end
    end

    // output process
    always_comb begin
        col_valid = (state_q != ST_IDLE);
        col_last  = (state_q == ST_BURST) && at_end;
        cfg_err   = err_q;
    end

    a_r2_first_beat_is_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (col_valid && col_addr == $past(cmd_col)));

    a_r3_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_start) |=> !col_valid);

    a_r4_upper_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !cmd_start && !cmd_stop && !col_last)
        |=> ((col_addr & ~mask_q) == ($past(col_addr) & ~$past(mask_q))));

    a_r6_page_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !cmd_start && !cmd_stop)
        |=> (col_valid && !col_last && col_addr == $past(col_addr) + 1'b1));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !col_valid);

    a_r10_last_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_start;
    logic [8:0] cmd_col;
    logic [2:0] len_code;
    logic       burst_ilv;
    logic       cmd_stop;
    logic       col_valid;
    logic [8:0] col_addr;
    logic       col_last;
    logic       cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string req = "R1";

    // reference model state
    bit m_act = 0;
    int m_base = 0;
    int m_idx = 0;
    int m_len = 1;   // 0 means full page
    bit m_ilv = 0;
    bit m_err = 0;

    always #10 clk = ~clk;

    burst_col_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_col(cmd_col),
        .len_code(len_code), .burst_ilv(burst_ilv), .cmd_stop(cmd_stop),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
        .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_addr();
        if (m_len == 0) return (m_base + m_idx) & 511;
        if (m_ilv) return m_base ^ m_idx;
        return (m_base & ~(m_len - 1) & 511) | ((m_base + m_idx) & (m_len - 1));
    endfunction

    task automatic model();
        if (cmd_start) begin
            m_act = 1; m_base = int'(cmd_col); m_idx = 0; m_ilv = burst_ilv;
            if (len_code <= 3'd3) m_len = 1 << len_code;
            else if (len_code == 3'd7 && !burst_ilv) m_len = 0;
            else begin m_len = 1; m_err = 1; m_ilv = 0; end
        end else if (cmd_stop) begin
            m_act = 0;
        end else if (m_act) begin
            if (m_len != 0 && m_idx == m_len - 1) m_act = 0;
            else m_idx = (m_idx + 1) & 511;
        end
    endtask

    task automatic compare();
        bit e_last;
        e_last = m_act && m_len != 0 && m_idx == m_len - 1;
        check(col_valid == m_act, "col_valid", int'(col_valid), int'(m_act));
        check(col_last == e_last, "col_last", int'(col_last), int'(e_last));
        check(cfg_err == m_err, "cfg_err", int'(cfg_err), int'(m_err));
        if (m_act) check(int'(col_addr) == exp_addr(), "col_addr", int'(col_addr), exp_addr());
    endtask

    task automatic step();
        @(posedge clk);
        model();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic go(input int col, input int code, input bit ilv);
        cmd_start = 1; cmd_col = 9'(col); len_code = 3'(code); burst_ilv = ilv;
        step();
        cmd_start = 0;
    endtask

    initial begin
        rst_n = 0; cmd_start = 0; cmd_stop = 0; cmd_col = '0; len_code = '0; burst_ilv = 0;
        @(negedge clk); @(negedge clk);
        req = "R1";
        check(!col_valid, "reset col_valid", int'(col_valid), 0);
        check(!col_last, "reset col_last", int'(col_last), 0);
        check(!cfg_err, "reset cfg_err", int'(cfg_err), 0);
        rst_n = 1;
        step();

        // R2 R3 R4: sequential fixed lengths
        req = "R3/R4 sequential";
        for (int c = 0; c < 4; c++) begin
            go(9'h1F5, c, 0); run(10);
            go(9'h0A2, c, 0); run(10);
        end
        // R5: interleaved
        req = "R5 interleaved";
        for (int c = 0; c < 4; c++) begin
            go(9'h0F3, c, 1); run(10);
            go(9'h10E, c, 1); run(10);
        end
        // R10 back-to-back single beats
        req = "R10 back-to-back";
        for (int i = 0; i < 6; i++) go(i * 37, 0, i[0]);
        run(3);
        // R6: full page wraps over whole column
        req = "R6 full page";
        go(9'h1FE, 7, 0); run(520);
        req = "R8 stop page";
        cmd_stop = 1; step(); cmd_stop = 0; run(3);
        // R8: stop mid burst, stop idle, start+stop priority
        req = "R8 stop";
        go(9'h040, 3, 0); run(2);
        cmd_stop = 1; step(); step(); cmd_stop = 0; run(3);
        cmd_stop = 1; cmd_start = 1; cmd_col = 9'h123; len_code = 3'd2; burst_ilv = 1;
        step(); cmd_stop = 0; cmd_start = 0; run(6);
        // R9: restart on various beats
        req = "R9 restart";
        for (int k = 0; k < 7; k++) begin
            go(9'h0C8 + k, 3, 0); run(k);
            go(9'h1B1 - k, 3, k[0]); run(9);
        end
        go(9'h010, 7, 0); run(5); go(9'h033, 2, 0); run(6);
        // R7: reserved codes, sticky error
        req = "R7 reserved";
        go(9'h155, 4, 0); run(3);
        go(9'h0AA, 5, 1); run(3);
        go(9'h001, 6, 0); run(3);
        go(9'h07F, 7, 1); run(3);
        go(9'h002, 2, 0); run(6);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule